// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit performs indivisible byte operations on data memory for a small processor core. A one-cycle start pulse selects one of four read-modify-write operations on the byte addressed by the Z pointer:

- exchange
- bit set
- bit clear
- bit toggle

Each of these reads the old byte, writes back a new byte formed from the old byte and the register operand, and hands the old byte back for register write-back.

The same sequencer also performs stack push and pop against an internal stack pointer. A push writes only. A pop reads only.

The memory side is a plain synchronous port: address, write data and write enable, with read data arriving one cycle after the address. Completion is signalled by a single-cycle done pulse. The register write-back strobe accompanies done for every operation that returns a byte. Arbitration of the memory port is left to the surrounding core.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, done, regWrite and memWe are low and spOut equals the parameter SP_RESET (default 0x00FF).
- R2: Operation code 0 (exchange) writes regIn to memory at zPtr and returns the old memory byte on regOut.
- R3: Operation code 1 (set) writes old OR regIn to memory at zPtr and returns the old byte.
- R4: Operation code 2 (clear) writes old AND NOT regIn to memory at zPtr and returns the old byte.
- R5: Operation code 3 (toggle) writes old XOR regIn to memory at zPtr and returns the old byte.
- R6: The address and operand are taken at the start pulse. Changes to zPtr or regIn afterwards have no effect on the operation in flight, and the four read-modify-write operations leave spOut unchanged.
- R7: Operation code 4 (push) writes regIn at the current stack pointer, then decrements the stack pointer by one. regWrite stays low for a push.
- R8: Operation code 5 (pop) increments the stack pointer by one, then reads the byte at the new pointer and returns it on regOut with regWrite high.
- R9: done is high for exactly one cycle. It appears on the 4th clock edge after the edge that samples start for read-modify-write operations, on the 2nd for push and on the 3rd for pop. regWrite is high only together with done.
- R10: A start pulse that arrives while an operation is in progress is ignored. Exactly one done follows, and the result is that of the first operation.
- R11: A start with operation code 6 or 7 is ignored. No memory write occurs, no done is produced and spOut is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| opCode | input | 3 | Operation select (0..5 valid) |
| regIn | input | 8 | Register operand |
| zPtr | input | ADDR_W | Z pointer byte address |
| memRdata | input | 8 | Memory read data, one cycle after address |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| regOut | output | 8 | Byte returned to the register file |
| regWrite | output | 1 | Register write-back strobe, with done |
| done | output | 1 | Completion pulse |
| spOut | output | ADDR_W | Current stack pointer |

## Verification
A wrong sequencer state shows at the ports within one operation:
- A skipped or repeated phase moves the done pulse off its expected edge.
- A missing or extra write shows at memWe.

A wrongly latched address or operand surfaces at the write-back edge, where the memory byte no longer matches the model. A stack pointer update on the wrong side of the access puts a push or pop at an address one away from the expected one. That error shows on spOut and on the byte returned by the next pop. Returning the written byte instead of the sampled byte is caught on the first set, clear or toggle whose result differs from the old byte.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [2:0] {
    OP_XCH  = 3'd0,
    OP_SET  = 3'd1,
    OP_CLR  = 3'd2,
    OP_TGL  = 3'd3,
    OP_PUSH = 3'd4,
    OP_POP  = 3'd5
  } rmw_op_e;

  localparam logic [2:0] OP_LAST = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } rmw_state_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // latch operands at accepted start
    logic capture;  // latch memory read data
    logic memWe;    // write phase
    logic spDec;    // stack pointer minus one
    logic spInc;    // stack pointer plus one
    logic done;     // completion
    logic regWr;    // register write-back
  } rmw_strobe_t;

  function automatic logic [7:0] mergeByte(input rmw_op_e op, input logic [7:0] oldByte,
                                           input logic [7:0] operand);
    case (op)
      OP_SET:  mergeByte = oldByte | operand;
      OP_CLR:  mergeByte = oldByte & ~operand;
      OP_TGL:  mergeByte = oldByte ^ operand;
      default: mergeByte = operand;
    endcase
  endfunction

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  opCode,
  output rmw_strobe_t strb
);

  rmw_state_e state, stateNext;
  rmw_op_e    kind;
  logic       accept;

  assign accept = (state == ST_IDLE) && start && (opCode <= OP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      kind  <= OP_XCH;
    end else begin
      state <= stateNext;
      if (accept) kind <= rmw_op_e'(opCode);
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strb.load = 1'b1;
          stateNext = (rmw_op_e'(opCode) == OP_PUSH) ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        strb.spInc = (kind == OP_POP);
        stateNext  = ST_WAIT;
      end
      ST_WAIT: begin
        strb.capture = 1'b1;
        stateNext    = (kind == OP_POP) ? ST_DONE : ST_WRITE;
      end
      ST_WRITE: begin
        strb.memWe = 1'b1;
        strb.spDec = (kind == OP_PUSH);
        stateNext  = ST_DONE;
      end
      ST_DONE: begin
        strb.done  = 1'b1;
        strb.regWr = (kind != OP_PUSH);
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R9: completion is a single-cycle pulse
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.done |=> !strb.done);

  // R9: every write phase is followed directly by completion
  assert_write_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.memWe |=> strb.done);

  // R10: no new operation is accepted while the unit is busy
  assert_busy_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> !($past(strb.load) && strb.load));

endmodule

// File: rtl/rmw_dp.sv
module rmw_dp
  import rmw_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rmw_strobe_t       strb,
  input  logic [2:0]        opCode,
  input  logic [7:0]        regIn,
  input  logic [ADDR_W-1:0] zPtr,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        regOut,
  output logic [ADDR_W-1:0] spOut
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  rmw_op_e           opReg;
  logic [7:0]        operand;
  logic [7:0]        oldByte;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] spReg;
  logic [ADDR_W-1:0] addrPick;

  always_comb begin
    case (rmw_op_e'(opCode))
      OP_PUSH: addrPick = spReg;
      OP_POP:  addrPick = spReg + ONE;
      default: addrPick = zPtr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opReg   <= OP_XCH;
      operand <= '0;
      oldByte <= '0;
      addrReg <= '0;
      spReg   <= SP_RESET;
    end else begin
      if (strb.load) begin
        opReg   <= rmw_op_e'(opCode);
        operand <= regIn;
        addrReg <= addrPick;
      end
      if (strb.capture) oldByte <= memRdata;
      if (strb.spDec) spReg <= spReg - ONE;
      else if (strb.spInc) spReg <= spReg + ONE;
    end
  end

  assign memAddr  = addrReg;
  assign memWdata = mergeByte(opReg, oldByte, operand);
  assign regOut   = oldByte;
  assign spOut    = spReg;

  // R6: latched address and operand hold for the whole operation
  assert_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> ($stable(addrReg) && $stable(operand)));

  // R7: push writes at the pointer value it then decrements
  assert_push_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.spDec |-> (addrReg == spReg));

  // R8: pop reads at the pointer value it increments to
  assert_pop_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.spInc |-> (addrReg == spReg + ONE));

  // R6: stack pointer moves only on push or pop strobes
  assert_sp_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.spDec || strb.spInc) |=> $stable(spReg));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import rmw_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        opCode,
  input  logic [7:0]        regIn,
  input  logic [ADDR_W-1:0] zPtr,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic [7:0]        regOut,
  output logic              regWrite,
  output logic              done,
  output logic [ADDR_W-1:0] spOut
);

  rmw_strobe_t strb;

  rmw_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opCode (opCode),
    .strb   (strb)
  );

  rmw_dp #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .opCode   (opCode),
    .regIn    (regIn),
    .zPtr     (zPtr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .regOut   (regOut),
    .spOut    (spOut)
  );

  assign memWe    = strb.memWe;
  assign done     = strb.done;
  assign regWrite = strb.regWr;

  // R9: register write-back only with completion
  assert_regwr_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regWrite |-> done);

endmodule

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;

  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] SP_RST = 16'h00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] opCode = '0;
  logic [7:0] regIn = '0;
  logic [ADDR_W-1:0] zPtr = '0;
  logic [7:0] memRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memWdata;
  logic memWe;
  logic [7:0] regOut;
  logic regWrite;
  logic done;
  logic [ADDR_W-1:0] spOut;

  int nTests = 0;
  int nFail = 0;
  int doneCnt = 0;
  int weCnt = 0;
  logic [7:0] mem [0:255];
  logic [7:0] expMem [0:255];
  logic [ADDR_W-1:0] expSp;

  always #5 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(ADDR_W), .SP_RESET(SP_RST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opCode(opCode), .regIn(regIn),
    .zPtr(zPtr), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .regOut(regOut), .regWrite(regWrite), .done(done), .spOut(spOut)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    memRdata <= mem[memAddr[7:0]];
    if (rst_n && done) doneCnt <= doneCnt + 1;
    if (rst_n && memWe) weCnt <= weCnt + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  function automatic logic [7:0] refMerge(input int op, input logic [7:0] o, input logic [7:0] r);
    case (op)
      1: return o | r;
      2: return o & ~r;
      3: return o ^ r;
      default: return r;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one operation; disturb changes zPtr/regIn and pulses start while busy.
  task automatic runOp(input int op, input logic [7:0] rv, input logic [7:0] z, input bit disturb);
    int lat;
    int expLat;
    int d0;
    logic [7:0] expOld;
    logic [ADDR_W-1:0] a;
    d0 = doneCnt;
    @(negedge clk);
    opCode = 3'(op); regIn = rv; zPtr = {8'h00, z}; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    if (disturb) begin
      opCode = 3'd1; regIn = ~rv; zPtr = {8'h00, z + 8'd7}; start = 1'b1;
      @(negedge clk); start = 1'b0; lat = 2;
    end
    while (!done && lat < 12) begin @(negedge clk); lat++; end
    if (op == 4) begin
      a = expSp; expMem[a[7:0]] = rv; expSp = expSp - 1'b1; expLat = 2;
      check("R7 regWrite low on push", int'(regWrite), 0);
    end else if (op == 5) begin
      expSp = expSp + 1'b1; a = expSp; expOld = expMem[a[7:0]]; expLat = 3;
      check("R8 pop data", int'(regOut), int'(expOld));
      check("R8 regWrite on pop", int'(regWrite), 1);
    end else begin
      a = {8'h00, z}; expOld = expMem[z];
      expMem[z] = refMerge(op, expOld, rv); expLat = 4;
      check($sformatf("R%0d returned old byte op%0d", op + 2, op), int'(regOut), int'(expOld));
      check("R9 regWrite with done", int'(regWrite), 1);
    end
    check("R9 latency", lat, expLat);
    @(negedge clk);
    check("R9 done single", int'(done), 0);
    check("R9 regWrite only with done", int'(regWrite), 0);
    check($sformatf("R%0d memory byte", op == 4 ? 7 : (op == 5 ? 8 : op + 2)),
          int'(mem[a[7:0]]), int'(expMem[a[7:0]]));
    check(op < 4 ? "R6 sp unchanged" : "R7 R8 sp update", int'(spOut), int'(expSp));
    if (disturb) begin
      repeat (6) @(negedge clk);
      check("R10 single done for busy start", doneCnt - d0, 1);
      check("R10 shifted byte untouched", int'(mem[z + 8'd7]), int'(expMem[z + 8'd7]));
      check("R6 first op result kept", int'(mem[z]), int'(expMem[z]));
    end
  endtask

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      expMem[i] = 8'(i * 37 + 5);
    end
    expSp = SP_RST;
    repeat (3) @(negedge clk);
    check("R1 done at reset", int'(done), 0);
    check("R1 memWe at reset", int'(memWe), 0);
    check("R1 regWrite at reset", int'(regWrite), 0);
    check("R1 sp at reset", int'(spOut), int'(SP_RST));
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    runOp(0, 8'hA5, 8'h10, 1'b0);   // R2 exchange
    runOp(1, 8'h0F, 8'h11, 1'b0);   // R3 set
    runOp(2, 8'hFF, 8'h12, 1'b0);   // R4 clear all
    runOp(3, 8'h5A, 8'h13, 1'b0);   // R5 toggle
    runOp(1, 8'h00, 8'h14, 1'b0);   // R3 set nothing
    runOp(4, 8'h3C, 8'h00, 1'b0);   // R7 push
    runOp(4, 8'hC3, 8'h00, 1'b0);   // R7 push
    runOp(5, 8'h00, 8'h00, 1'b0);   // R8 pop returns 0xC3
    runOp(5, 8'h00, 8'h00, 1'b0);   // R8 pop returns 0x3C
    runOp(3, 8'hFF, 8'h20, 1'b1);   // R10 busy start ignored, R6 zPtr change
    runOp(0, 8'h77, 8'h30, 1'b1);   // R10

    // R11: invalid opcodes
    for (int k = 6; k < 8; k++) begin
      int d0;
      int w0;
      d0 = doneCnt; w0 = weCnt;
      @(negedge clk);
      opCode = 3'(k); regIn = 8'h99; zPtr = 16'h0040; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      check("R11 no done for invalid op", doneCnt - d0, 0);
      check("R11 no write for invalid op", weCnt - w0, 0);
      check("R11 sp unchanged", int'(spOut), int'(expSp));
    end

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      runOp(op, 8'($urandom), 8'($urandom_range(0, 127)), ($urandom_range(0, 7) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule